// File: doc/BRIEF.md
# Load/Store Address and Data Sizing Unit

This unit sits between a core's register read stage and its data memory port for single-register loads and stores. Each request supplies a base value, an offset taken from one of three sources and an indexing mode. From these the unit forms the byte address sent to memory and the updated base value that may be written back. The offset source is a zero-extended immediate, a register value, or a register value shifted left by a constant. An up/down control chooses whether the offset is added to the base or subtracted from it.

The same request carries the access width (byte, halfword or word) and a signedness flag. For stores, the unit copies the narrow register data across every lane of the 32-bit bus and enables only the lanes that the low address bits select, in little-endian order. For loads, it picks the addressed lane out of the 32-bit read word and sign-extends or zero-extends it to a full word. All outputs are registered and appear one clock after the request.

Top module: `ls_size_unit`

## Requirements
- R1: While `rstN` is low, and at the first clock after it, every output is zero.
- R2: Offset mode (`idxMode`=0, and also code 3) puts base±offset on `memAddr` and keeps `wbEn` low.
- R3: Pre-indexed mode (`idxMode`=1) puts base±offset on `memAddr`, raises `wbEn`, and drives that same sum on `wbValue`.
- R4: Post-indexed mode (`idxMode`=2) puts the unmodified base on `memAddr`, raises `wbEn`, and drives base±offset on `wbValue`.
- R5: The offset is the 12-bit `immOffset` zero-extended when `offSel`=0, `regOffset` when `offSel`=1, and `regOffset << shiftAmt` when `offSel` is 2 or 3.
- R6: When `addUp`=1 the offset is added to the base, and when `addUp`=0 it is subtracted, modulo 2^32.
- R7: `memByteEn` bit i enables byte lane i. A byte access (`accSize`=0) sets only bit `memAddr[1:0]`. A halfword (`accSize`=1) sets 4'b0011 when `memAddr[1]`=0 and 4'b1100 when it is 1. A word (`accSize`=2, or code 3) sets 4'b1111.
- R8: A store drives `memWdata` with the low byte repeated four times, the low halfword repeated twice, or the full word, according to size. `memWdata` is zero on loads.
- R9: A byte load takes bits [8k+7:8k] of `rdData`, where k=`memAddr[1:0]`. A halfword load takes bits [31:16] when `memAddr[1]`=1 and bits [15:0] otherwise. A word load takes all of `rdData`.
- R10: When `signedLd`=1, a narrow load copies the lane's top bit into all upper bits of `ldResult`; otherwise the upper bits are zero (a byte 0x80 gives 0xFFFFFF80 or 0x00000080). `ldResult` is zero on stores.
- R11: In a cycle after no request, `memRead`, `memWrite`, `memByteEn` and `wbEn` are all zero. `memRead` and `memWrite` are never high together.
- R12: A request presented with `reqValid` high produces its outputs after exactly one rising clock edge, with `memWrite` set for a store (`isStore`=1) and `memRead` set for a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| isStore | input | 1 | 1 store, 0 load |
| baseVal | input | 32 | Base register value |
| immOffset | input | 12 | Immediate offset, zero-extended |
| regOffset | input | 32 | Offset register value |
| offSel | input | 2 | Offset source: 0 imm, 1 reg, 2/3 reg shifted |
| shiftAmt | input | 5 | Left shift applied to the register offset |
| idxMode | input | 2 | 0 offset, 1 pre-indexed, 2 post-indexed, 3 as offset |
| addUp | input | 1 | 1 add offset, 0 subtract |
| accSize | input | 2 | 0 byte, 1 halfword, 2/3 word |
| signedLd | input | 1 | Sign-extend narrow loads |
| rdData | input | 32 | Read word from memory |
| storeReg | input | 32 | Register data to store |
| memAddr | output | 32 | Byte address of the access |
| memByteEn | output | 4 | Lane enables, bit i = byte lane i |
| memRead | output | 1 | Load access |
| memWrite | output | 1 | Store access |
| memWdata | output | 32 | Lane-replicated store data |
| ldResult | output | 32 | Extended load result |
| wbValue | output | 32 | New base value |
| wbEn | output | 1 | Base writeback enable |

## Verification
The bench targets the cases where the modes differ. In post-indexed mode the address must be the old base even though the writeback carries the sum; a design that swapped the two values would put the updated base on the memory address. Byte loads at lane 3 and halfword loads at the upper half catch lane selection that ignores the low address bits. Signed and unsigned loads of 0x80 and 0x8000 expose an extension taken from the wrong bit or skipped altogether. Subtracting with borrow and shifting the register offset to large amounts check that the offset path is neither truncated nor added where it should be subtracted.

// File: rtl/ls_size_pkg.sv
package ls_size_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } accSize_e;

  typedef enum logic [1:0] {
    IX_OFFSET = 2'd0,
    IX_PRE    = 2'd1,
    IX_POST   = 2'd2
  } idxMode_e;

  typedef struct packed {
    logic     valid;
    logic     isWrite;
    logic     addrFromSum;
    logic     wbWanted;
    accSize_e size;
    logic     sext;
  } lsCtrl_t;

endpackage

// File: rtl/ls_size_ctrl.sv
module ls_size_ctrl
  import ls_size_pkg::*;
(
  input  logic        reqValid,
  input  logic        isStore,
  input  logic [1:0]  idxMode,
  input  logic [1:0]  accSize,
  input  logic        signedLd,
  output lsCtrl_t     ctrl
);

  always_comb begin
    ctrl.valid       = reqValid;
    ctrl.isWrite     = isStore;
    // post-indexed uses the old base; offset and pre use the sum
    ctrl.addrFromSum = (idxMode != IX_POST);
    ctrl.wbWanted    = (idxMode == IX_PRE) || (idxMode == IX_POST);
    case (accSize)
      2'd0:    ctrl.size = SZ_BYTE;
      2'd1:    ctrl.size = SZ_HALF;
      default: ctrl.size = SZ_WORD;
    endcase
    ctrl.sext = signedLd && !isStore;
  end

  always_comb begin
    if (ctrl.addrFromSum == 1'b0) begin
      a_r4_post_no_sum_addr: assert (ctrl.wbWanted);
    end
  end

endmodule

// File: rtl/ls_size_datapath.sv
module ls_size_datapath
  import ls_size_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 12,
  parameter int SH_W   = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  lsCtrl_t              ctrl,
  input  logic [DATA_W-1:0]    baseVal,
  input  logic [IMM_W-1:0]     immOffset,
  input  logic [DATA_W-1:0]    regOffset,
  input  logic [1:0]           offSel,
  input  logic [SH_W-1:0]      shiftAmt,
  input  logic                 addUp,
  input  logic [DATA_W-1:0]    rdData,
  input  logic [DATA_W-1:0]    storeReg,
  output logic [DATA_W-1:0]    memAddr,
  output logic [DATA_W/8-1:0]  memByteEn,
  output logic                 memRead,
  output logic                 memWrite,
  output logic [DATA_W-1:0]    memWdata,
  output logic [DATA_W-1:0]    ldResult,
  output logic [DATA_W-1:0]    wbValue,
  output logic                 wbEn
);

  localparam int LANES = DATA_W / 8;
  localparam int LW    = $clog2(LANES);
  localparam int HALVES = LANES / 2;

  logic [DATA_W-1:0] offVal;
  logic [DATA_W-1:0] sumVal;
  logic [DATA_W-1:0] effAddr;
  logic [LW-1:0]     laneIdx;
  logic [LANES-1:0]  beByte;
  logic [LANES-1:0]  beHalf;
  logic [LANES-1:0]  beNext;
  logic [DATA_W-1:0] wdNext;
  logic [7:0]        byteLane;
  logic [15:0]       halfLane;
  logic [DATA_W-1:0] ldNext;

  // offset source and adder
  always_comb begin
    case (offSel)
      2'd0:    offVal = {{(DATA_W-IMM_W){1'b0}}, immOffset};
      2'd1:    offVal = regOffset;
      default: offVal = regOffset << shiftAmt;
    endcase
    sumVal  = addUp ? (baseVal + offVal) : (baseVal - offVal);
    effAddr = ctrl.addrFromSum ? sumVal : baseVal;
    laneIdx = effAddr[LW-1:0];
  end

  // per-lane enables
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign beByte[i] = (laneIdx == LW'(i));
    assign beHalf[i] = (laneIdx[LW-1:1] == (LW-1)'(i >> 1));
  end

  always_comb begin
    case (ctrl.size)
      SZ_BYTE: begin
        beNext = beByte;
        wdNext = {LANES{storeReg[7:0]}};
      end
      SZ_HALF: begin
        beNext = beHalf;
        wdNext = {HALVES{storeReg[15:0]}};
      end
      default: begin
        beNext = '1;
        wdNext = storeReg;
      end
    endcase
  end

  // load lane pick and extension
  always_comb begin
    byteLane = rdData[{laneIdx, 3'b000} +: 8];
    halfLane = rdData[{laneIdx[LW-1:1], 4'b0000} +: 16];
    case (ctrl.size)
      SZ_BYTE: ldNext = {{(DATA_W-8){ctrl.sext & byteLane[7]}}, byteLane};
      SZ_HALF: ldNext = {{(DATA_W-16){ctrl.sext & halfLane[15]}}, halfLane};
      default: ldNext = rdData;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr   <= '0;
      memByteEn <= '0;
      memRead   <= 1'b0;
      memWrite  <= 1'b0;
      memWdata  <= '0;
      ldResult  <= '0;
      wbValue   <= '0;
      wbEn      <= 1'b0;
    end else begin
      memAddr   <= effAddr;
      memByteEn <= ctrl.valid ? beNext : '0;
      memRead   <= ctrl.valid && !ctrl.isWrite;
      memWrite  <= ctrl.valid && ctrl.isWrite;
      memWdata  <= (ctrl.valid && ctrl.isWrite) ? wdNext : '0;
      ldResult  <= (ctrl.valid && !ctrl.isWrite) ? ldNext : '0;
      wbValue   <= sumVal;
      wbEn      <= ctrl.valid && ctrl.wbWanted;
    end
  end

  // R4: post-indexed access goes to the unmodified base
  a_r4_post_uses_base: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.valid && !ctrl.addrFromSum) |=> (memAddr == $past(baseVal)));

  // R2: offset mode never writes the base back
  a_r2_offset_no_wb: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.valid && !ctrl.wbWanted) |=> !wbEn);

  // R10: unsigned byte load has zero upper bits
  a_r10_unsigned_zero_fill: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.valid && !ctrl.isWrite && !ctrl.sext && ctrl.size == SZ_BYTE)
      |=> (ldResult[DATA_W-1:8] == '0));

  // R11: idle cycle is quiet
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.valid |=> (memByteEn == '0 && !wbEn && !memRead && !memWrite));

  // R11: never read and write at once
  a_r11_rw_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(memRead && memWrite));

  // R7: enabled lane count is 1, 2 or all
  a_r7_byteen_count: assert property (@(posedge clk) disable iff (!rstN)
    (memRead || memWrite) |-> ($countones(memByteEn) == 1 ||
      $countones(memByteEn) == 2 || $countones(memByteEn) == LANES));

  // R12: a request yields an access one edge later
  a_r12_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.valid |=> (memRead || memWrite));

endmodule

// File: rtl/ls_size_unit.sv
module ls_size_unit
  import ls_size_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 12,
  parameter int SH_W   = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 isStore,
  input  logic [DATA_W-1:0]    baseVal,
  input  logic [IMM_W-1:0]     immOffset,
  input  logic [DATA_W-1:0]    regOffset,
  input  logic [1:0]           offSel,
  input  logic [SH_W-1:0]      shiftAmt,
  input  logic [1:0]           idxMode,
  input  logic                 addUp,
  input  logic [1:0]           accSize,
  input  logic                 signedLd,
  input  logic [DATA_W-1:0]    rdData,
  input  logic [DATA_W-1:0]    storeReg,
  output logic [DATA_W-1:0]    memAddr,
  output logic [DATA_W/8-1:0]  memByteEn,
  output logic                 memRead,
  output logic                 memWrite,
  output logic [DATA_W-1:0]    memWdata,
  output logic [DATA_W-1:0]    ldResult,
  output logic [DATA_W-1:0]    wbValue,
  output logic                 wbEn
);

  lsCtrl_t ctrl;

  ls_size_ctrl u_ctrl (
    .reqValid (reqValid),
    .isStore  (isStore),
    .idxMode  (idxMode),
    .accSize  (accSize),
    .signedLd (signedLd),
    .ctrl     (ctrl)
  );

  ls_size_datapath #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W),
    .SH_W   (SH_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .baseVal   (baseVal),
    .immOffset (immOffset),
    .regOffset (regOffset),
    .offSel    (offSel),
    .shiftAmt  (shiftAmt),
    .addUp     (addUp),
    .rdData    (rdData),
    .storeReg  (storeReg),
    .memAddr   (memAddr),
    .memByteEn (memByteEn),
    .memRead   (memRead),
    .memWrite  (memWrite),
    .memWdata  (memWdata),
    .ldResult  (ldResult),
    .wbValue   (wbValue),
    .wbEn      (wbEn)
  );

endmodule

// File: tb/ls_size_unit_test.sv
module ls_size_unit_test;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, isStore, addUp, signedLd;
  logic [31:0] baseVal, regOffset, rdData, storeReg;
  logic [11:0] immOffset;
  logic [1:0]  offSel, idxMode, accSize;
  logic [4:0]  shiftAmt;
  logic [31:0] memAddr, memWdata, ldResult, wbValue;
  logic [3:0]  memByteEn;
  logic        memRead, memWrite, wbEn;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ls_size_unit uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .isStore(isStore),
    .baseVal(baseVal), .immOffset(immOffset), .regOffset(regOffset),
    .offSel(offSel), .shiftAmt(shiftAmt), .idxMode(idxMode), .addUp(addUp),
    .accSize(accSize), .signedLd(signedLd), .rdData(rdData), .storeReg(storeReg),
    .memAddr(memAddr), .memByteEn(memByteEn), .memRead(memRead),
    .memWrite(memWrite), .memWdata(memWdata), .ldResult(ldResult),
    .wbValue(wbValue), .wbEn(wbEn)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idleInputs();
    reqValid = 0; isStore = 0; baseVal = 0; immOffset = 0; regOffset = 0;
    offSel = 0; shiftAmt = 0; idxMode = 0; addUp = 1; accSize = 2;
    signedLd = 0; rdData = 0; storeReg = 0;
  endtask

  // one request, model computed from the requirements, full output check
  task automatic access(input string tag, input logic st, input logic [31:0] b,
      input logic [11:0] imm, input logic [31:0] ro, input logic [1:0] sel,
      input logic [4:0] sh, input logic [1:0] md, input logic up,
      input logic [1:0] sz, input logic sg, input logic [31:0] rd,
      input logic [31:0] sr);
    logic [31:0] off, sum, addr, wd, ld, lane;
    logic [3:0]  be;
    logic        wb;
    @(negedge clk);
    reqValid = 1; isStore = st; baseVal = b; immOffset = imm; regOffset = ro;
    offSel = sel; shiftAmt = sh; idxMode = md; addUp = up; accSize = sz;
    signedLd = sg; rdData = rd; storeReg = sr;
    off  = (sel == 0) ? {20'd0, imm} : (sel == 1) ? ro : (ro << sh);
    sum  = up ? b + off : b - off;
    addr = (md == 2) ? b : sum;
    wb   = (md == 1) || (md == 2);
    if (sz == 0) begin
      be = 4'b0001 << addr[1:0]; wd = {4{sr[7:0]}};
      lane = (rd >> (8 * addr[1:0])) & 32'hFF;
      ld = (sg && lane[7]) ? (lane | 32'hFFFFFF00) : lane;
    end else if (sz == 1) begin
      be = addr[1] ? 4'b1100 : 4'b0011; wd = {2{sr[15:0]}};
      lane = addr[1] ? {16'd0, rd[31:16]} : {16'd0, rd[15:0]};
      ld = (sg && lane[15]) ? (lane | 32'hFFFF0000) : lane;
    end else begin
      be = 4'b1111; wd = sr; ld = rd;
    end
    if (st) ld = 0; else wd = 0;
    @(negedge clk);
    reqValid = 0;
    chk({tag, " addr"}, memAddr, addr);
    chk({tag, " byteEn"}, {28'd0, memByteEn}, {28'd0, be});
    chk({tag, " R12 rd/wr"}, {30'd0, memRead, memWrite}, {30'd0, !st, st});
    chk({tag, " wdata"}, memWdata, wd);
    chk({tag, " ldResult"}, ldResult, ld);
    chk({tag, " wbEn"}, {31'd0, wbEn}, {31'd0, wb});
    if (wb) chk({tag, " wbValue"}, wbValue, sum);
  endtask

  task automatic tReset();
    rstN = 0; idleInputs();
    reqValid = 1; isStore = 1;
    repeat (2) @(negedge clk);
    chk("R1 addr", memAddr, 0);
    chk("R1 controls", {28'd0, memByteEn} | {31'd0, memRead} | {31'd0, memWrite} | {31'd0, wbEn}, 0);
    chk("R1 data", memWdata | ldResult | wbValue, 0);
    rstN = 1; reqValid = 0; isStore = 0;
  endtask

  task automatic tOffsetMode();
    access("R2 offset imm", 0, 32'h2000_0000, 12'h012, 0, 0, 0, 0, 1, 2, 0, 32'hCAFE_F00D, 0);
    access("R2 mode3", 1, 32'h100, 12'h8, 0, 0, 0, 3, 1, 2, 0, 0, 32'h1234_5678);
  endtask

  task automatic tPre();
    access("R3 pre", 1, 32'h2000_0000, 12'h004, 0, 0, 0, 1, 1, 2, 0, 0, 32'hFFFF_FF80);
  endtask

  task automatic tPost();
    access("R4 post", 0, 32'h0000_1000, 0, 32'h20, 1, 0, 2, 1, 2, 0, 32'h0BAD_BEEF, 0);
  endtask

  task automatic tSources();
    access("R5 reg", 0, 32'h3000, 0, 32'h0000_0104, 1, 0, 1, 1, 2, 0, 32'h1, 0);
    access("R5 shift2", 0, 32'h3000, 12'hFFF, 32'h5, 2, 2, 1, 1, 2, 0, 32'h2, 0);
    access("R5 shift31", 0, 32'h0, 0, 32'h1, 3, 31, 1, 1, 2, 0, 32'h3, 0);
  endtask

  task automatic tSubtract();
    access("R6 sub", 0, 32'h0000_0010, 12'h020, 0, 0, 0, 1, 0, 2, 0, 32'h4, 0);
    access("R6 sub post", 0, 32'h1000, 0, 32'h3, 2, 2, 2, 0, 2, 0, 32'h5, 0);
  endtask

  task automatic tStoreLanes();
    for (int k = 0; k < 4; k++)
      access("R7 R8 store byte", 1, 32'h4000, 12'(k), 0, 0, 0, 0, 1, 0, 0, 0, 32'hAABB_CC5A);
    access("R7 R8 store half lo", 1, 32'h4000, 0, 0, 0, 0, 0, 1, 1, 0, 0, 32'h1122_BEEF);
    access("R7 R8 store half hi", 1, 32'h4002, 0, 0, 0, 0, 0, 1, 1, 0, 0, 32'h1122_BEEF);
  endtask

  task automatic tLoads();
    access("R9 byte lane3 unsigned", 0, 32'h5003, 0, 0, 0, 0, 0, 1, 0, 0, 32'h8011_2233, 0);
    access("R10 byte 0x80 signed", 0, 32'h5003, 0, 0, 0, 0, 0, 1, 0, 1, 32'h8011_2233, 0);
    access("R10 byte 0x80 unsigned", 0, 32'h5000, 0, 0, 0, 0, 0, 1, 0, 0, 32'h0000_0080, 0);
    chk("R10 example unsigned", ldResult, 32'h0000_0080);
    access("R10 byte 0x80 signed lane0", 0, 32'h5000, 0, 0, 0, 0, 0, 1, 0, 1, 32'h0000_0080, 0);
    chk("R10 example signed", ldResult, 32'hFFFF_FF80);
    access("R9 R10 half hi signed", 0, 32'h5002, 0, 0, 0, 0, 0, 1, 1, 1, 32'h8000_7FFF, 0);
    access("R9 R10 half lo signed", 0, 32'h5000, 0, 0, 0, 0, 0, 1, 1, 1, 32'h8000_7FFF, 0);
    access("R10 half hi unsigned", 0, 32'h5002, 0, 0, 0, 0, 0, 1, 1, 0, 32'h8000_7FFF, 0);
    access("R9 word size3", 0, 32'h5001, 0, 0, 0, 0, 0, 1, 3, 1, 32'h8765_4321, 0);
  endtask

  task automatic tIdle();
    access("R11 pre before idle", 0, 32'h10, 12'h4, 0, 0, 0, 1, 1, 2, 0, 32'h9, 0);
    @(negedge clk);
    chk("R11 idle quiet", {28'd0, memByteEn} | {31'd0, memRead} | {31'd0, memWrite} | {31'd0, wbEn}, 0);
  endtask

  initial begin
    fork
      begin
        tReset();
        tOffsetMode();
        tPre();
        tPost();
        tSources();
        tSubtract();
        tStoreLanes();
        tLoads();
        tIdle();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule